// File: doc/BRIEF.md
# Serial Bus Response Receiver and Poller

This block takes over a two-wire serial bus right after a command frame has gone out. It owns the bus clock and turns the bidirectional data line around to listen. It waits for the slave's start bit and then decodes the reply that follows: a 2-bit message id, a 2-bit response code, optional read data and a 4-bit check code. When the reply is complete it reports success, one of several error classes, or the read data. The data line is active low. Every value named below is the logical value, which is the inverse of the pin level.

A busy slave is handled inside the block. The block clocks idle cycles, sends a fixed 9-bit poll frame, waits out the line echo and then listens again. It gives up after a bounded number of polls. A missing start bit, an error response code and a bad check code each end the operation with their own error code. A good reply is followed by a run of idle clocks that leaves the slave ready for the next command.

Top module: `srp_resp_poller`

## Requirements
- R1: Outside an operation (after reset and after `done`), `sclk_o` is held high, `sdat_oe` is 1, `sdat_o` is 1 (logical 0) and `done` is 0.
- R2: A `start` pulse in idle turns the line to input (`sdat_oe`=0) from the next cycle and begins bus clock pulses of one low cycle and one high cycle each. During the high cycle the block samples `sdat_i` and inverts it. The first logical 1 sampled is the start bit.
- R3: If 1000 consecutive pulses sample logical 0, the block sets error code 4 and clocks 20 more input pulses to drain the line before `done`. A start bit on pulse 1000 is still accepted.
- R4: The 4 bits after the start bit are the id (first two bits) and the response code (last two bits), MSB first. Code 0 is ACK, code 1 is BUSY, and codes 2 and 3 are error replies.
- R5: On ACK for a read (`rd_op`=1), the block receives 8, 16 or 32 data bits, MSB first, for `rd_size` = 0, 1, or 2/3. `rdata` returns them right-aligned and zero-extended. `rdata` is 0 after any write or failed operation.
- R6: On ACK for a write (`rd_op`=0), no data bits follow the code, and the 4 check bits come next.
- R7: The check code is a CRC with polynomial x^4+x^2+x+1 and zero seed, shifted MSB first over a leading 1, the id, the code and any data bits. A received value that differs sets error code 5, and `done` follows directly after the last check bit.
- R8: After a matching check code the block gives 100 more input pulses, then raises `done` with `err`=0 and error code 0.
- R9: On BUSY, the block drives the line for 100 pulses at logical 0, then a logical 1 start bit and the 9-bit poll frame 0x02A MSB first, then 16 pulses at logical 0. It then listens again with a fresh 1000-pulse timeout.
- R10: A BUSY reply that arrives after 100 poll frames have already been sent ends the operation at once with error code 1.
- R11: On response code 2 or 3, the block gives 4 more pulses, then raises `done` with `err`=1 and an error code equal to the response code.
- R12: `done` is high for exactly one cycle. `err`, `err_code` and `rdata` hold their values until the next accepted `start`. A `start` during an operation is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin listening for a reply (idle only) |
| rd_op | input | 1 | 1 when the preceding command was a read |
| rd_size | input | 2 | Read size: 0 = 1 byte, 1 = 2 bytes, 2/3 = 4 bytes |
| sclk_o | output | 1 | Bus clock, idles high |
| sdat_o | output | 1 | Data pin level when driving (active low) |
| sdat_oe | output | 1 | 1 when the block drives the data pin |
| sdat_i | input | 1 | Data pin level when listening (active low) |
| done | output | 1 | One-cycle end-of-operation strobe |
| err | output | 1 | Operation failed |
| err_code | output | 3 | 0 none, 1 stuck busy, 2/3 slave error reply, 4 timeout, 5 check-code mismatch |
| rdata | output | 32 | Read data, right-aligned |

## Verification
The bench counts every bus clock pulse from `start` to `done` and compares the count against the reply length plus the trailing drain, error or priming run. An off-by-one in any counter changes that total. The timeout is tested at both sides of its edge: a start bit on the 1000th pulse must be accepted, and 1000 idle pulses must time out. A design that counted one pulse too few would time out on a legal reply. Every re-poll window is captured bit by bit and checked for length and for the poll pattern, which catches a missing start bit or a wrong echo length. The stuck-busy case checks that exactly 100 polls go out, so a design that polled once more or once less, or that failed to reload its timeout, would be caught. A check code flipped by one bit must give error 5. Read data is checked at all three widths, so a design that dropped or added a data bit would fail both the data check and the pulse count.

// File: rtl/srp_pkg.sv
package srp_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_WAIT, S_HDR, S_DATA, S_CRC, S_TAIL,
    S_PRIME, S_DRAIN, S_PIDLE, S_PTX, S_ECHO
  } srp_state_t;

  localparam logic [2:0] E_NONE = 3'd0;
  localparam logic [2:0] E_BUSY = 3'd1;
  localparam logic [2:0] E_TMO  = 3'd4;
  localparam logic [2:0] E_CRC  = 3'd5;

  localparam logic [1:0] C_ACK  = 2'd0;
  localparam logic [1:0] C_BUSY = 2'd1;

  // one serial step of the 4-bit check code, MSB first
  function automatic logic [3:0] crc4_step(logic [3:0] c, logic b, logic [3:0] poly);
    logic fb;
    fb = c[3] ^ b;
    return {c[2:0], 1'b0} ^ (fb ? poly : 4'h0);
  endfunction

  function automatic logic [5:0] data_bits(logic [1:0] sz);
    case (sz)
      2'd0:    return 6'd8;
      2'd1:    return 6'd16;
      default: return 6'd32;
    endcase
  endfunction

  function automatic logic [31:0] width_mask(logic [5:0] n);
    if (n >= 6'd32) return '1;
    return (32'h1 << n) - 32'h1;
  endfunction

  function automatic int max_of(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/srp_clk_gen.sv
module srp_clk_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sclk,
  output logic step
);
  logic phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    phase <= 1'b0;
    else if (!run) phase <= 1'b0;
    else           phase <= ~phase;
  end

  assign sclk = run ? phase : 1'b1;
  assign step = run & phase;

  // R1: bus clock idles high whenever no operation runs
  p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> sclk);

  // R2: a pulse never spans two high cycles in a row while running
  p_pulse_shape_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && step) |=> (!run || !sclk));
endmodule

// File: rtl/srp_rx_shift.sv
module srp_rx_shift #(
  parameter logic [3:0] POLY = 4'h7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        shift_en,
  input  logic        crc_en,
  input  logic        bit_in,
  output logic [31:0] shreg_nxt,
  output logic [3:0]  crc_acc
);
  import srp_pkg::*;

  logic [31:0] shreg;

  assign shreg_nxt = {shreg[30:0], bit_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg   <= '0;
      crc_acc <= '0;
    end else if (clr) begin
      shreg   <= '0;
      crc_acc <= crc4_step(4'h0, 1'b1, POLY);  // leading start bit
    end else begin
      if (shift_en) shreg <= shreg_nxt;
      if (shift_en && crc_en) crc_acc <= crc4_step(crc_acc, bit_in, POLY);
    end
  end

  // R7: the accumulator stays frozen while check bits are being received
  p_crc_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !(shift_en && crc_en)) |=> $stable(crc_acc));
endmodule

// File: rtl/srp_poll_tx.sv
module srp_poll_tx #(
  parameter int                  POLL_BITS = 9,
  parameter logic [POLL_BITS-1:0] POLL_CODE = 'h2A
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic adv,
  output logic tx_bit,
  output logic tx_last
);
  localparam int FW = POLL_BITS + 1;
  localparam int IW = $clog2(FW + 1);

  logic [FW-1:0] sr;
  logic [IW-1:0] idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr  <= '0;
      idx <= '0;
    end else if (load) begin
      sr  <= {1'b1, POLL_CODE};
      idx <= '0;
    end else if (adv) begin
      sr  <= sr << 1;
      idx <= idx + 1'b1;
    end
  end

  assign tx_bit  = sr[FW-1];
  assign tx_last = (idx == IW'(FW - 1));

  // R9: a freshly loaded frame opens with the logical-1 start bit
  p_start_bit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> tx_bit);

  // R9: the frame never runs past start bit plus poll code
  p_frame_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= IW'(FW - 1) || !adv);
endmodule

// File: rtl/srp_resp_poller.sv
module srp_resp_poller #(
  parameter int                   TMO_CLKS   = 1000,
  parameter int                   DRAIN_CLKS = 20,
  parameter int                   PIDLE_CLKS = 100,
  parameter int                   ECHO_CLKS  = 16,
  parameter int                   PRIME_CLKS = 100,
  parameter int                   TAIL_CLKS  = 4,
  parameter int                   MAX_BUSY   = 100,
  parameter int                   POLL_BITS  = 9,
  parameter logic [POLL_BITS-1:0] POLL_CODE  = 'h2A,
  parameter logic [3:0]           CRC_POLY   = 4'h7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        rd_op,
  input  logic [1:0]  rd_size,
  output logic        sclk_o,
  output logic        sdat_o,
  output logic        sdat_oe,
  input  logic        sdat_i,
  output logic        done,
  output logic        err,
  output logic [2:0]  err_code,
  output logic [31:0] rdata
);
  import srp_pkg::*;

  localparam int MAXC  = max_of(max_of(max_of(TMO_CLKS, DRAIN_CLKS), max_of(PIDLE_CLKS, PRIME_CLKS)),
                                max_of(max_of(ECHO_CLKS, TAIL_CLKS), 32));
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam int PW    = $clog2(MAX_BUSY + 1);

  srp_state_t       state;
  logic [CNT_W-1:0] cnt;
  logic [PW-1:0]    polls;
  logic             rd_q;
  logic [5:0]       nbits_q;
  logic [31:0]      data_q;

  // named internal events
  logic        run, step, bit_in;
  logic        start_seen, hdr_last, data_last, crc_last, crc_match;
  logic        tx_bit, tx_last, tx_load, tx_adv;
  logic        rx_shift, rx_crc_en;
  logic [31:0] rx_nxt;
  logic [3:0]  crc_acc;
  logic [1:0]  rsp_code;

  assign run        = (state != S_IDLE);
  assign bit_in     = ~sdat_i;
  assign start_seen = step && (state == S_WAIT) && bit_in;
  assign hdr_last   = (state == S_HDR)  && (cnt == CNT_W'(3));
  assign data_last  = (state == S_DATA) && (cnt == CNT_W'(nbits_q - 6'd1));
  assign crc_last   = (state == S_CRC)  && (cnt == CNT_W'(3));
  assign crc_match  = (rx_nxt[3:0] == crc_acc);
  assign rsp_code   = rx_nxt[1:0];
  assign rx_shift   = step && (state inside {S_HDR, S_DATA, S_CRC});
  assign rx_crc_en  = (state inside {S_HDR, S_DATA});
  assign tx_load    = step && (state == S_PIDLE) && (cnt == CNT_W'(PIDLE_CLKS - 1));
  assign tx_adv     = step && (state == S_PTX);

  srp_clk_gen u_clk (
    .clk(clk), .rst_n(rst_n), .run(run), .sclk(sclk_o), .step(step)
  );

  srp_rx_shift #(.POLY(CRC_POLY)) u_rx (
    .clk(clk), .rst_n(rst_n), .clr(start_seen), .shift_en(rx_shift),
    .crc_en(rx_crc_en), .bit_in(bit_in), .shreg_nxt(rx_nxt), .crc_acc(crc_acc)
  );

  srp_poll_tx #(.POLL_BITS(POLL_BITS), .POLL_CODE(POLL_CODE)) u_tx (
    .clk(clk), .rst_n(rst_n), .load(tx_load), .adv(tx_adv),
    .tx_bit(tx_bit), .tx_last(tx_last)
  );

  // line drive: only while idle or re-polling
  assign sdat_oe = (state inside {S_IDLE, S_PIDLE, S_PTX, S_ECHO});
  assign sdat_o  = ~((state == S_PTX) ? tx_bit : 1'b0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cnt      <= '0;
      polls    <= '0;
      rd_q     <= 1'b0;
      nbits_q  <= 6'd8;
      data_q   <= '0;
      rdata    <= '0;
      err      <= 1'b0;
      err_code <= E_NONE;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (state == S_IDLE) begin
        if (start) begin
          state    <= S_WAIT;
          cnt      <= '0;
          polls    <= '0;
          rd_q     <= rd_op;
          nbits_q  <= data_bits(rd_size);
          data_q   <= '0;
          rdata    <= '0;
          err      <= 1'b0;
          err_code <= E_NONE;
        end
      end else if (step) begin
        cnt <= cnt + 1'b1;
        case (state)
          S_WAIT: begin
            if (bit_in) begin
              state <= S_HDR;
              cnt   <= '0;
            end else if (cnt == CNT_W'(TMO_CLKS - 1)) begin
              state    <= S_DRAIN;
              cnt      <= '0;
              err      <= 1'b1;
              err_code <= E_TMO;
            end
          end
          S_HDR: if (hdr_last) begin
            cnt <= '0;
            case (rsp_code)
              C_ACK:  state <= rd_q ? S_DATA : S_CRC;
              C_BUSY: begin
                if (polls == PW'(MAX_BUSY)) begin
                  state    <= S_IDLE;
                  done     <= 1'b1;
                  err      <= 1'b1;
                  err_code <= E_BUSY;
                end else begin
                  polls <= polls + 1'b1;
                  state <= S_PIDLE;
                end
              end
              default: begin
                state    <= S_TAIL;
                err      <= 1'b1;
                err_code <= {1'b0, rsp_code};
              end
            endcase
          end
          S_DATA: if (data_last) begin
            cnt    <= '0;
            data_q <= rx_nxt & width_mask(nbits_q);
            state  <= S_CRC;
          end
          S_CRC: if (crc_last) begin
            cnt <= '0;
            if (crc_match) begin
              state <= S_PRIME;
              rdata <= data_q;
            end else begin
              state    <= S_IDLE;
              done     <= 1'b1;
              err      <= 1'b1;
              err_code <= E_CRC;
            end
          end
          S_TAIL:  if (cnt == CNT_W'(TAIL_CLKS - 1))  begin state <= S_IDLE; done <= 1'b1; end
          S_PRIME: if (cnt == CNT_W'(PRIME_CLKS - 1)) begin state <= S_IDLE; done <= 1'b1; end
          S_DRAIN: if (cnt == CNT_W'(DRAIN_CLKS - 1)) begin state <= S_IDLE; done <= 1'b1; end
          S_PIDLE: if (tx_load) begin state <= S_PTX; cnt <= '0; end
          S_PTX:   if (tx_last) begin state <= S_ECHO; cnt <= '0; end
          S_ECHO:  if (cnt == CNT_W'(ECHO_CLKS - 1))  begin state <= S_WAIT; cnt <= '0; end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  // R12: completion strobe lasts one cycle
  p_done_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R12: error flag and code agree at completion
  p_err_coded_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (err == (err_code != E_NONE)));

  // R12: results hold while idle and no new operation starts
  p_rdata_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && !start) |=> ($stable(rdata) && $stable(err_code)));

  // R10: poll count never exceeds its bound
  p_poll_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    polls <= PW'(MAX_BUSY));

  // R3: the start-bit wait never outlives the timeout window
  p_wait_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WAIT) |-> (cnt < CNT_W'(TMO_CLKS)));

  // R2: the line is released while a reply is being received
  p_listen_released_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_shift |-> !sdat_oe);
endmodule

// File: tb/srp_resp_poller_test.sv
`timescale 1ns/1ps
module srp_resp_poller_test;
  localparam int WIN_LEN = 126;
  localparam logic [WIN_LEN-1:0] WIN_EXP = {100'b0, 1'b1, 9'h02A, 16'b0};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        rd_op = 1'b0;
  logic [1:0]  rd_size = 2'd0;
  logic        sclk_o, sdat_o, sdat_oe;
  logic        sdat_i = 1'b1;
  logic        done, err;
  logic [2:0]  err_code;
  logic [31:0] rdata;

  int n_chk = 0, n_err = 0;

  // slave script
  logic [63:0] r_vec [8];
  int r_len [8];
  int r_lead [8];
  int n_resp = 1;
  int op_seq = 0, seen_seq = 0;
  int ridx = 0, cur = 0, pos = 0;
  // monitors
  int pulses = 0, win_cnt = 0, win_bad = 0, win_n = 0;
  logic [WIN_LEN-1:0] win = '0;
  logic prev_oe = 1'b1, prev_sclk = 1'b1;

  always #2.5 clk = ~clk;

  srp_resp_poller uut (
    .clk(clk), .rst_n(rst_n), .start(start), .rd_op(rd_op), .rd_size(rd_size),
    .sclk_o(sclk_o), .sdat_o(sdat_o), .sdat_oe(sdat_oe), .sdat_i(sdat_i),
    .done(done), .err(err), .err_code(err_code), .rdata(rdata)
  );

  function automatic logic rsp_bit(int c, int p);
    if (p < r_lead[c]) return 1'b0;
    if (p - r_lead[c] < r_len[c]) return r_vec[c][r_len[c] - 1 - (p - r_lead[c])];
    return 1'b0;
  endfunction

  // remainder of msg*x^4 divided by x^4+x^2+x+1
  function automatic logic [3:0] ref_crc(logic [63:0] msg, int len);
    logic [63:0] rem;
    rem = msg << 4;
    for (int i = len + 3; i >= 4; i--)
      if (rem[i]) rem = rem ^ (64'h17 << (i - 4));
    return rem[3:0];
  endfunction

  always @(posedge clk) begin
    #1;
    if (op_seq != seen_seq) begin seen_seq = op_seq; ridx = 0; end
    if (prev_oe && !sdat_oe) begin
      if (win_n > 0) begin
        win_cnt++;
        if (win_n != WIN_LEN || win != WIN_EXP) win_bad++;
      end
      win_n = 0;
      cur = (ridx < n_resp) ? ridx : n_resp - 1;
      ridx++;
      pos = 0;
    end
    if (!prev_sclk && sclk_o) begin
      pulses++;
      if (sdat_oe) begin win = {win[WIN_LEN-2:0], ~sdat_o}; win_n++; end
    end
    if (prev_sclk && !sclk_o && !sdat_oe) begin
      sdat_i = ~rsp_bit(cur, pos);
      pos++;
    end
    if (sdat_oe) sdat_i = 1'b1;
    prev_oe = sdat_oe;
    prev_sclk = sclk_o;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_rsp(input int i, input int lead, input logic [1:0] id, input logic [1:0] code,
                         input logic [31:0] data, input int n, input logic bad);
    logic [63:0] msg;
    logic [3:0] c;
    msg = (64'h1 << (4 + n)) | (64'(id) << (2 + n)) | (64'(code) << n) |
          (64'(data) & ((64'h1 << n) - 64'h1));
    c = ref_crc(msg, 5 + n);
    if (bad) c = c ^ 4'h1;
    r_vec[i] = (msg << 4) | 64'(c);
    r_len[i] = 9 + n;
    r_lead[i] = lead;
  endtask

  // run one operation; returns pulse count and re-poll window stats
  task automatic do_op(input logic rd, input logic [1:0] sz, input int spur_at,
                       output int np, output int nw, output int nbad);
    int p0, w0, b0, cyc;
    p0 = pulses; w0 = win_cnt; b0 = win_bad;
    op_seq++;
    @(posedge clk); #1;
    rd_op = rd; rd_size = sz; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    cyc = 0;
    while (!done) begin
      @(posedge clk); #1;
      cyc++;
      start = (cyc == spur_at);
      if (cyc > 60000) begin
        n_err++;
        $display("FAIL R12: watchdog actual=no done expected=done");
        break;
      end
    end
    start = 1'b0;
    np = pulses - p0; nw = win_cnt - w0; nbad = win_bad - b0;
    @(posedge clk); #1;
    chk("R12 done one cycle", done, 0);
    // inputs changed after completion must not disturb held results
    rd_op = ~rd; rd_size = ~sz;
  endtask

  task automatic t_reset;
    chk("R1 sclk idle", sclk_o, 1);
    chk("R1 oe idle", sdat_oe, 1);
    chk("R1 data idle", sdat_o, 1);
    chk("R1 done idle", done, 0);
  endtask

  task automatic t_write_ack;
    int np, nw, nb;
    n_resp = 1; set_rsp(0, 3, 2'd2, 2'd0, 0, 0, 0);
    do_op(1'b0, 2'd2, 0, np, nw, nb);
    chk("R6 write pulses", np, 3 + 5 + 4 + 100);
    chk("R8 write err", err, 0);
    chk("R8 write code", err_code, 0);
    chk("R5 write rdata", rdata, 0);
    chk("R1 sclk after op", sclk_o, 1);
  endtask

  task automatic t_read(input logic [1:0] sz, input int n, input logic [31:0] d, input int lead,
                        input logic [1:0] id);
    int np, nw, nb;
    n_resp = 1; set_rsp(0, lead, id, 2'd0, d, n, 0);
    do_op(1'b1, sz, 0, np, nw, nb);
    chk("R5 read pulses", np, lead + 5 + n + 4 + 100);
    chk("R5 read data", rdata, (n == 32) ? d : (d & ((32'h1 << n) - 1)));
    chk("R4 read err", err, 0);
  endtask

  task automatic t_crc_bad;
    int np, nw, nb;
    n_resp = 1; set_rsp(0, 2, 2'd1, 2'd0, 32'h5A, 8, 1);
    do_op(1'b1, 2'd0, 0, np, nw, nb);
    chk("R7 crc pulses", np, 2 + 5 + 8 + 4);
    chk("R7 crc err", err, 1);
    chk("R7 crc code", err_code, 5);
    chk("R7 crc rdata", rdata, 0);
  endtask

  task automatic t_err_code(input logic [1:0] code);
    int np, nw, nb;
    n_resp = 1; set_rsp(0, 4, 2'd0, code, 0, 0, 0);
    do_op(1'b1, 2'd2, 0, np, nw, nb);
    chk("R11 err pulses", np, 4 + 5 + 4);
    chk("R11 err flag", err, 1);
    chk("R11 err code", err_code, 3'(code));
  endtask

  task automatic t_timeout;
    int np, nw, nb;
    n_resp = 1; r_len[0] = 0; r_lead[0] = 0; r_vec[0] = 0;
    do_op(1'b0, 2'd0, 0, np, nw, nb);
    chk("R3 timeout pulses", np, 1000 + 20);
    chk("R3 timeout code", err_code, 4);
    chk("R3 timeout err", err, 1);
  endtask

  task automatic t_late_start;
    int np, nw, nb;
    n_resp = 1; set_rsp(0, 999, 2'd3, 2'd0, 0, 0, 0);
    do_op(1'b0, 2'd0, 0, np, nw, nb);
    chk("R3 start on last pulse err", err, 0);
    chk("R3 start on last pulse count", np, 999 + 5 + 4 + 100);
  endtask

  task automatic t_busy_recover;
    int np, nw, nb;
    n_resp = 3;
    set_rsp(0, 3, 2'd1, 2'd1, 0, 0, 0);
    set_rsp(1, 0, 2'd1, 2'd1, 0, 0, 0);
    set_rsp(2, 4, 2'd1, 2'd0, 32'hC3A1, 16, 0);
    do_op(1'b1, 2'd1, 0, np, nw, nb);
    chk("R9 busy polls", nw, 2);
    chk("R9 poll window shape", nb, 0);
    chk("R9 busy pulses", np, (3 + 5 + WIN_LEN) + (5 + WIN_LEN) + (4 + 5 + 16 + 4 + 100));
    chk("R9 busy then data", rdata, 32'hC3A1);
    chk("R9 busy then ok", err, 0);
  endtask

  task automatic t_stuck_busy;
    int np, nw, nb;
    n_resp = 1; set_rsp(0, 0, 2'd0, 2'd1, 0, 0, 0);
    do_op(1'b0, 2'd0, 0, np, nw, nb);
    chk("R10 stuck polls", nw, 100);
    chk("R10 stuck windows", nb, 0);
    chk("R10 stuck pulses", np, 101 * 5 + 100 * WIN_LEN);
    chk("R10 stuck code", err_code, 1);
  endtask

  task automatic t_spurious_start;
    int np, nw, nb;
    n_resp = 1; set_rsp(0, 6, 2'd2, 2'd0, 32'h96, 8, 0);
    do_op(1'b1, 2'd0, 40, np, nw, nb);
    chk("R12 start ignored pulses", np, 6 + 5 + 8 + 4 + 100);
    chk("R12 start ignored data", rdata, 32'h96);
    repeat (10) @(posedge clk);
    #1;
    chk("R12 data held", rdata, 32'h96);
    chk("R12 err held", err, 0);
    chk("R1 oe after op", sdat_oe, 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_err++;
    $display("FAIL R12: global watchdog actual=hung expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    t_reset();
    t_write_ack();
    t_read(2'd0, 8, 32'h0000_00A5, 0, 2'd1);
    t_read(2'd1, 16, 32'h0000_BEEF, 5, 2'd2);
    t_read(2'd2, 32, 32'hDEAD_BEEF, 2, 2'd3);
    t_read(2'd3, 32, 32'h1234_5678, 1, 2'd0);
    t_crc_bad();
    t_err_code(2'd2);
    t_err_code(2'd3);
    t_timeout();
    t_late_start();
    t_busy_recover();
    t_stuck_busy();
    t_spurious_start();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule